// File: doc/BRIEF.md
# Two-Source Interrupt Latch and Arbiter

This block watches two interrupt sources for a processor core. One is an internal buffer-full request. The other is an external interrupt pin. It records each source in a status register, which holds one pending bit per source. It then decides which source the core services next. The decision is made at fixed sampling points. As a result, the source that wins depends on how many cycles the external request arrives after the buffer-full request. A request that arrives too late to join the current decision stays pending and is offered to the core later.

Towards the core, the block raises a request together with a one-bit vector select. The core answers with an accept strobe, and the block then pulses an active-low acknowledge for one cycle. The core also supplies:
- a return strobe that closes the service,
- an interruptible-instruction strobe that gates new requests,
- a strobe for reads of the serial data buffer, which clears the buffer-full bit.

A single global enable can hold back all requests.

Top module: `irq_pair_arbiter`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0, `ack_n` is 1 and `stat` is 2'b00.
- R2: A rising buffer-full input is registered once before its edge is detected. The external pin passes through SYNC_STAGES (default 2) more flops. When both sources line up at the sampling point, the status bits set one clock later and `irq_req` rises one clock after that.
- R3: When both sources reach the sampling point in the same cycle, the external source is serviced (`irq_vec`=1, where 1 means external and 0 means buffer-full). At that point `stat` is 2'b11, with bit 1 for external and bit 0 for buffer-full.
- R4: When the external source reaches the sampling point one cycle after the buffer-full source, the buffer-full source is serviced (`irq_vec`=0) and `stat` already reads 2'b11 when `irq_req` rises.
- R5: When the external source arrives two or more cycles after the buffer-full source, the buffer-full source is serviced with `stat`=2'b01 when `irq_req` rises. The external bit sets later and stays pending.
- R6: While `irq_req` waits, `irq_vec` stays constant. After `take` is seen with `irq_req` high, `ack_n` goes low for exactly one cycle and `irq_req` drops.
- R7: The external bit clears at the edge where `ack_n` goes low for an external service. The buffer-full bit is not cleared by acknowledge. It clears only on `buf_rd`.
- R8: `ret` does not clear either status bit. A pending source is requested at the first clock after `ret` where `intr_ok` is high.
- R9: From acceptance until `ret`, no new `irq_req` is raised, but new requests still set their status bits.
- R10: No request is raised while `en` or `intr_ok` is low, and `take` without `irq_req` produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global interrupt enable |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| buf_full | input | 1 | Internal buffer-full request level |
| take | input | 1 | Core accepts the pending request |
| ret | input | 1 | Core returns from the interrupt |
| intr_ok | input | 1 | Core is at an interruptible instruction |
| buf_rd | input | 1 | Core reads the serial data buffer |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 1 | Serviced source, 1 external, 0 buffer-full |
| ack_n | output | 1 | Active-low acknowledge pulse |
| stat | output | 2 | Status bits, [1] external, [0] buffer-full |

## Verification
The bench sweeps the external arrival offset from zero to three cycles after the buffer-full request and checks the winner and the status snapshot at each offset. A design that decides one cycle late would give the wrong source or a merged status at offset one. A design that lets acknowledge or return clear the wrong bit loses the pending external request or re-services the buffer-full source. Directed cases cover requests arriving during a service, requests blocked by the enable and interruptible strobes, and a stray accept strobe. A design that leaks a request through while busy would raise `irq_req` early.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
  typedef enum logic {
    SRC_BUF = 1'b0,
    SRC_EXT = 1'b1
  } irq_src_e;
endpackage

// File: rtl/irq_pair_sampler.sv
module irq_pair_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_pin,
  input  logic buf_full,
  output logic ext_ev,
  output logic buf_ev
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic ext_smp, ext_prev, buf_smp, buf_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_smp  <= 1'b0;
      ext_prev <= 1'b0;
      buf_smp  <= 1'b0;
      buf_prev <= 1'b0;
    end else begin
      ext_smp  <= sync_q[LAST];
      ext_prev <= ext_smp;
      buf_smp  <= buf_full;
      buf_prev <= buf_smp;
    end
  end

  assign ext_ev = ext_smp & ~ext_prev;
  assign buf_ev = buf_smp & ~buf_prev;
endmodule

// File: rtl/irq_pair_status.sv
module irq_pair_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_ev,
  input  logic       buf_ev,
  input  logic       ack_ext,
  input  logic       ack_buf,
  input  logic       buf_rd,
  output logic [1:0] stat,
  output logic       pend_ext,
  output logic       pend_buf
);
  logic st_ext, st_buf, buf_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_ext   <= 1'b0;
      st_buf   <= 1'b0;
      buf_done <= 1'b0;
    end else begin
      if (ext_ev)       st_ext <= 1'b1;
      else if (ack_ext) st_ext <= 1'b0;

      if (buf_ev)      st_buf <= 1'b1;
      else if (buf_rd) st_buf <= 1'b0;

      if (buf_ev)       buf_done <= 1'b0;
      else if (ack_buf) buf_done <= 1'b1;
      else if (!st_buf) buf_done <= 1'b0;
    end
  end

  assign stat     = {st_ext, st_buf};
  assign pend_ext = st_ext;
  assign pend_buf = st_buf & ~buf_done;
endmodule

// File: rtl/irq_pair_issue.sv
module irq_pair_issue
  import irq_pair_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic intr_ok,
  input  logic take,
  input  logic ret,
  input  logic pend_ext,
  input  logic pend_buf,
  output logic irq_req,
  output logic irq_vec,
  output logic ack_n,
  output logic busy,
  output logic ack_ext,
  output logic ack_buf
);
  logic accept, issue;
  irq_src_e pick;

  assign accept  = irq_req & take;
  assign issue   = ~busy & ~irq_req & en & intr_ok & (pend_ext | pend_buf);
  assign pick    = pend_ext ? SRC_EXT : SRC_BUF;
  assign ack_ext = accept & (irq_vec == SRC_EXT);
  assign ack_buf = accept & (irq_vec == SRC_BUF);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= SRC_BUF;
      ack_n   <= 1'b1;
      busy    <= 1'b0;
    end else begin
      ack_n <= ~accept;
      if (accept) begin
        irq_req <= 1'b0;
        busy    <= 1'b1;
      end else begin
        if (issue) begin
          irq_req <= 1'b1;
          irq_vec <= pick;
        end
        if (ret) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_pair_arbiter.sv
module irq_pair_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ext_pin,
  input  logic       buf_full,
  input  logic       take,
  input  logic       ret,
  input  logic       intr_ok,
  input  logic       buf_rd,
  output logic       irq_req,
  output logic       irq_vec,
  output logic       ack_n,
  output logic [1:0] stat
);
  logic ext_ev, buf_ev;
  logic pend_ext, pend_buf;
  logic ack_ext, ack_buf;
  logic svc_busy;

  irq_pair_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .ext_pin  (ext_pin),
    .buf_full (buf_full),
    .ext_ev   (ext_ev),
    .buf_ev   (buf_ev)
  );

  irq_pair_status u_status (
    .clk      (clk),
    .rst      (rst),
    .ext_ev   (ext_ev),
    .buf_ev   (buf_ev),
    .ack_ext  (ack_ext),
    .ack_buf  (ack_buf),
    .buf_rd   (buf_rd),
    .stat     (stat),
    .pend_ext (pend_ext),
    .pend_buf (pend_buf)
  );

  irq_pair_issue u_issue (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .intr_ok  (intr_ok),
    .take     (take),
    .ret      (ret),
    .pend_ext (pend_ext),
    .pend_buf (pend_buf),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .ack_n    (ack_n),
    .busy     (svc_busy),
    .ack_ext  (ack_ext),
    .ack_buf  (ack_buf)
  );
endmodule

// File: rtl/irq_pair_arbiter_chk.sv
module irq_pair_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       take,
  input logic       intr_ok,
  input logic       buf_rd,
  input logic       irq_req,
  input logic       irq_vec,
  input logic       ack_n,
  input logic [1:0] stat,
  input logic       svc_busy
);
  assert_ack_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |=> ack_n);

  assert_ack_follows_take_R6: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> $past(irq_req && take));

  assert_vec_held_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !take) |=> (irq_req && $stable(irq_vec)));

  assert_buf_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(stat[0]) |-> $past(buf_rd));

  assert_ext_clear_on_ack_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(stat[1]) |-> ($fell(ack_n) && irq_vec));

  assert_no_issue_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(!svc_busy && en && intr_ok));

  assert_ext_priority_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> (irq_vec == $past(stat[1])));
endmodule

bind irq_pair_arbiter irq_pair_arbiter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .take     (take),
  .intr_ok  (intr_ok),
  .buf_rd   (buf_rd),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .ack_n    (ack_n),
  .stat     (stat),
  .svc_busy (svc_busy)
);

// File: tb/irq_pair_arbiter_bench.sv
module irq_pair_arbiter_bench;
  localparam int SYNC = 2;

  // {offset[1:0], first vec, stat at request[1:0], stat after ack[1:0], second vec}
  localparam logic [7:0] TBL [4] = '{
    8'b00_1_11_01_0,
    8'b01_0_11_11_1,
    8'b10_0_01_11_1,
    8'b11_0_01_11_1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, ext_pin = 1'b0, buf_full = 1'b0, take = 1'b0;
  logic ret = 1'b0, intr_ok = 1'b0, buf_rd = 1'b0;
  logic irq_req, irq_vec, ack_n;
  logic [1:0] stat;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_pair_arbiter #(.SYNC_STAGES(SYNC)) u_irq_pair_arbiter (
    .clk(clk), .rst(rst), .en(en), .ext_pin(ext_pin), .buf_full(buf_full),
    .take(take), .ret(ret), .intr_ok(intr_ok), .buf_rd(buf_rd),
    .irq_req(irq_req), .irq_vec(irq_vec), .ack_n(ack_n), .stat(stat)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; ext_pin = 1'b0; buf_full = 1'b0; take = 1'b0;
    ret = 1'b0; intr_ok = 1'b0; buf_rd = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 ack_n", int'(ack_n), 1);
    chk("R1 stat", int'(stat), 0);

    for (int v = 0; v < 4; v++) begin
      int d, waited;
      string tag;
      d = int'(TBL[v][7:6]);
      tag = (d == 0) ? "R3" : (d == 1) ? "R4" : "R5";
      do_reset();
      en = 1'b1; intr_ok = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (i == 2) buf_full = 1'b1;
        if (i == d + 2 - SYNC) ext_pin = 1'b1;
        step(1);
      end
      waited = 0;
      while (!irq_req && waited < 20) begin step(1); waited++; end
      chk("R2 request latency", waited, 1);
      chk({tag, " first vec"}, int'(irq_vec), int'(TBL[v][5]));
      chk({tag, " stat at request"}, int'(stat), int'(TBL[v][4:3]));
      step(3);
      chk("R6 request held", int'(irq_req), 1);
      chk("R6 vec stable", int'(irq_vec), int'(TBL[v][5]));
      take = 1'b1; step(1); take = 1'b0;
      chk("R6 ack low", int'(ack_n), 0);
      chk("R6 req dropped", int'(irq_req), 0);
      chk("R7 stat after ack", int'(stat), int'(TBL[v][2:1]));
      step(1);
      chk("R6 ack one cycle", int'(ack_n), 1);
      step(2);
      chk("R9 no request in service", int'(irq_req), 0);
      intr_ok = 1'b0; ret = 1'b1; step(1); ret = 1'b0;
      step(3);
      chk("R8 held until interruptible", int'(irq_req), 0);
      chk("R8 return keeps status", int'(stat), int'(TBL[v][2:1]));
      intr_ok = 1'b1; step(1);
      chk("R8 pending taken", int'(irq_req), 1);
      chk("R8 second vec", int'(irq_vec), int'(TBL[v][0]));
      take = 1'b1; step(1); take = 1'b0; step(1);
      ret = 1'b1; step(1); ret = 1'b0;
      chk("R7 buf bit survives ack", int'(stat), 1);
      buf_rd = 1'b1; step(1); buf_rd = 1'b0;
      buf_full = 1'b0; ext_pin = 1'b0; step(1);
      chk("R7 read clears buf bit", int'(stat), 0);
    end

    do_reset();
    chk("R1 irq_req", int'(irq_req), 0);
    take = 1'b1; step(1); take = 1'b0;
    chk("R10 stray take", int'(ack_n), 1);
    intr_ok = 1'b1; buf_full = 1'b1; step(6);
    chk("R10 blocked by enable", int'(irq_req), 0);
    chk("R10 latched while disabled", int'(stat), 1);
    en = 1'b1; step(1);
    chk("R10 issued on enable", int'(irq_req), 1);
    chk("R10 buf vec", int'(irq_vec), 0);
    take = 1'b1; step(1); take = 1'b0; step(1);
    ext_pin = 1'b1; step(6);
    chk("R9 latched in service", int'(stat), 3);
    chk("R9 no request in service", int'(irq_req), 0);
    ret = 1'b1; step(1); ret = 1'b0; step(1);
    chk("R9 request after return", int'(irq_req), 1);
    chk("R9 ext vec", int'(irq_vec), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule